// File: doc/BRIEF.md
# Flash Read-Mode Command Controller

This block is the read side of the command interface of a NOR-style flash device. A host writes command bytes on the bidirectional data bus with the write strobe. Each valid command selects what later reads return: the contents of the memory array, identification data, or the status byte. The selected mode stays in force across any number of reads until another valid command arrives. Any byte that is not a known command leaves the mode as it was.

In identification mode the read address selects a fixed manufacturer code, a density-dependent device code, or a per-block configuration byte. That byte reports whether the block is locked and whether its last erase failed. The lock and erase-fail flags come from test inputs, because programming and erasure are not part of this block. In status mode the block holds the status byte in a latch. The latch loads when the last of the chip enables and output enable goes low. It then keeps its value until one of those strobes goes high and low again. All strobes are active-low and are sampled on the system clock. The data bus is driven only during a read.

Top module: `flash_rdcmd_ctrl`

## Requirements
- R1: After reset the block is in array mode and the data bus is not driven (high-impedance).
- R2: One clock after ce0_n, ce1_n and oe_n are all low and we_n is high, the block drives the data bus. One clock after any of those conditions stops holding, the bus returns to high-impedance.
- R3: A byte present on the data bus while we_n is low is taken as a command at the rising edge of we_n. FFh selects array mode, 90h selects identification mode and 70h selects status mode. Any other byte, such as 40h, leaves the mode unchanged.
- R4: A rising edge of we_n while ce0_n or ce1_n is high is not taken as a command, and the mode is unchanged.
- R5: In array mode a read of byte address a returns ((a*29) mod 256) XOR 5Ah.
- R6: In identification mode, word offset 0 (address bits [3:1] equal to 0) of block 0 returns the manufacturer code 89h. Word offset 1 of block 0 returns the device code: D0h for the 16 Mbit setting (default) or D4h for the 32 Mbit setting. Address bit 0 is ignored.
- R7: In identification mode, word offset 2 of block b (block number in address bits [5:4]) returns a byte with bit 0 equal to blk_lock[b], bit 1 equal to blk_efail[b], and bits 7 to 2 equal to zero.
- R8: In identification mode, every other address returns 00h.
- R9: In status mode, the value of status_src is captured on the clock where the last of ce0_n, ce1_n and oe_n is first seen low. That value is returned while the read stays active, even if status_src changes.
- R10: The status latch loads a new value only after oe_n or a chip enable has returned high and the read has become active again.
- R11: The selected mode persists across reads and through enable toggles until another valid command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce0_n | input | 1 | Chip enable 0, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; command taken at its rising edge |
| addr | input | ADDR_W (6) | Byte address; upper bits select the block |
| data | inout | 8 | Command input and read data output |
| status_src | input | 8 | Live status value offered to the status latch |
| blk_lock | input | NUM_BLK (4) | Test input: per-block lock flag |
| blk_efail | input | NUM_BLK (4) | Test input: per-block erase-failed flag |

## Verification
A wrong mode register is visible at the next read. Array, identification and status data differ at every address the bench uses, so a mode that was taken from an invalid command or a disabled write shows up within two clocks of the following read. A status latch that refreshes too often, or not at all, shows up one clock after status_src changes under a held read, or one clock after the read is re-armed. A bus-enable fault shows up one clock after the strobes change, as a driven value where high-impedance is expected or the reverse.

// File: rtl/flash_rdcmd_pkg.sv
package flash_rdcmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;

  // Mode after a command byte; unknown bytes keep the current mode.
  function automatic rd_mode_e next_mode(input logic [7:0] cmd, input rd_mode_e cur);
    case (cmd)
      CMD_ARRAY:  return MODE_ARRAY;
      CMD_IDENT:  return MODE_IDENT;
      CMD_STATUS: return MODE_STATUS;
      default:    return cur;
    endcase
  endfunction

  // Power-up pattern of the array register file.
  function automatic logic [7:0] array_seed(input logic [15:0] a);
    logic [15:0] prod;
    prod = a * 16'd29;
    return prod[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] dev_code(input bit big);
    return big ? 8'hD4 : 8'hD0;
  endfunction

  function automatic logic [7:0] blk_cfg_byte(input logic lock, input logic efail);
    return {6'b0, efail, lock};
  endfunction

endpackage

// File: rtl/frc_cmd_fsm.sv
module frc_cmd_fsm
  import flash_rdcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_rise,
  input  logic [7:0] cmd_byte,
  output rd_mode_e   mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
    end else if (we_rise) begin
      mode_q <= next_mode(cmd_byte, mode_q);
    end
  end

endmodule

// File: rtl/frc_stat_latch.sv
module frc_stat_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_act,
  input  logic [7:0] status_src,
  output logic       rd_go,
  output logic [7:0] stat_q
);

  logic rd_act_q;

  assign rd_go = rd_act & ~rd_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      stat_q   <= 8'h00;
    end else begin
      rd_act_q <= rd_act;
      if (rd_go) begin
        stat_q <= status_src;
      end
    end
  end

endmodule

// File: rtl/frc_array.sv
module frc_array
  import flash_rdcmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[gi] <= array_seed(16'(gi));
      end else begin
        mem[gi] <= mem[gi];
      end
    end
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/frc_id_rom.sv
module frc_id_rom
  import flash_rdcmd_pkg::*;
#(
  parameter int         NUM_BLK  = 4,
  parameter int         OFS_W    = 4,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter bit         BIG_SIZE = 1'b0
) (
  input  logic [$clog2(NUM_BLK)+OFS_W-1:1] waddr,
  input  logic [NUM_BLK-1:0]               blk_lock,
  input  logic [NUM_BLK-1:0]               blk_efail,
  output logic [7:0]                       id_data
);

  localparam int BLK_W  = $clog2(NUM_BLK);
  localparam int ADDR_W = BLK_W + OFS_W;

  logic [BLK_W-1:0] blk;
  logic [OFS_W-1:1] wofs;
  logic [7:0]       cfg [NUM_BLK];

  assign blk  = waddr[ADDR_W-1:OFS_W];
  assign wofs = waddr[OFS_W-1:1];

  for (genvar gb = 0; gb < NUM_BLK; gb++) begin : g_cfg
    assign cfg[gb] = blk_cfg_byte(blk_lock[gb], blk_efail[gb]);
  end

  always_comb begin
    id_data = 8'h00;
    if (wofs == (OFS_W-1)'(2)) begin
      id_data = cfg[blk];
    end else if (blk == '0 && wofs == '0) begin
      id_data = MFR_CODE;
    end else if (blk == '0 && wofs == (OFS_W-1)'(1)) begin
      id_data = dev_code(BIG_SIZE);
    end
  end

endmodule

// File: rtl/flash_rdcmd_ctrl.sv
module flash_rdcmd_ctrl
  import flash_rdcmd_pkg::*;
#(
  parameter int         NUM_BLK  = 4,
  parameter int         OFS_W    = 4,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter bit         BIG_SIZE = 1'b0,
  localparam int        ADDR_W   = $clog2(NUM_BLK) + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0_n,
  input  logic              ce1_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [7:0]        data,
  input  logic [7:0]        status_src,
  input  logic [NUM_BLK-1:0] blk_lock,
  input  logic [NUM_BLK-1:0] blk_efail
);

  // Named internal events
  logic       chip_en;
  logic       rd_act;
  logic       we_rise;
  logic       rd_go;
  logic       bus_oe;
  rd_mode_e   mode_q;
  logic [7:0] stat_q;
  logic [7:0] arr_data;
  logic [7:0] id_data;
  logic [7:0] dout;

  logic       we_q;
  logic       en_q;
  logic [7:0] din_q;

  assign chip_en = ~ce0_n & ~ce1_n;
  assign rd_act  = chip_en & ~oe_n & we_n;
  assign we_rise = we_n & ~we_q & chip_en & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      en_q   <= 1'b0;
      din_q  <= 8'h00;
      bus_oe <= 1'b0;
    end else begin
      we_q   <= we_n;
      en_q   <= chip_en;
      din_q  <= data;
      bus_oe <= rd_act;
    end
  end

  frc_cmd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_rise  (we_rise),
    .cmd_byte (din_q),
    .mode_q   (mode_q)
  );

  frc_stat_latch u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_act     (rd_act),
    .status_src (status_src),
    .rd_go      (rd_go),
    .stat_q     (stat_q)
  );

  frc_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_data (arr_data)
  );

  frc_id_rom #(
    .NUM_BLK  (NUM_BLK),
    .OFS_W    (OFS_W),
    .MFR_CODE (MFR_CODE),
    .BIG_SIZE (BIG_SIZE)
  ) u_id (
    .waddr     (addr[ADDR_W-1:1]),
    .blk_lock  (blk_lock),
    .blk_efail (blk_efail),
    .id_data   (id_data)
  );

  always_comb begin
    case (mode_q)
      MODE_IDENT:  dout = id_data;
      MODE_STATUS: dout = stat_q;
      default:     dout = arr_data;
    endcase
  end

  assign data = bus_oe ? dout : 8'hzz;

endmodule

// File: rtl/frc_chk.sv
module frc_chk
  import flash_rdcmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ce0_n,
  input logic       ce1_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       bus_oe,
  input logic       rd_act,
  input logic       we_rise,
  input rd_mode_e   mode_q,
  input logic [7:0] stat_q
);

  // R2
  bus_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce0_n && !ce1_n && !oe_n && we_n) |=> bus_oe);

  // R2
  bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce0_n || ce1_n || oe_n || !we_n) |=> !bus_oe);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_rise |=> $stable(mode_q));

  // R4
  no_cmd_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce0_n || ce1_n) |=> $stable(mode_q));

  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && $past(rd_act)) |=> $stable(stat_q));

  // R10
  stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> ($past(rd_act) && !$past(rd_act, 2)));

endmodule

bind flash_rdcmd_ctrl frc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce0_n   (ce0_n),
  .ce1_n   (ce1_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .bus_oe  (bus_oe),
  .rd_act  (rd_act),
  .we_rise (we_rise),
  .mode_q  (mode_q),
  .stat_q  (stat_q)
);

// File: tb/flash_rdcmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_rdcmd_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce0_n = 1'b1;
  logic       ce1_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       we_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] status_src = 8'h00;
  logic [3:0] blk_lock = 4'b0000;
  logic [3:0] blk_efail = 4'b0000;
  logic [7:0] tb_drv = 8'h00;
  logic       tb_oe = 1'b0;
  wire  [7:0] data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign data = tb_oe ? tb_drv : 8'hzz;

  always #4 clk = ~clk;

  flash_rdcmd_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce0_n      (ce0_n),
    .ce1_n      (ce1_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .addr       (addr),
    .data       (data),
    .status_src (status_src),
    .blk_lock   (blk_lock),
    .blk_efail  (blk_efail)
  );

  function automatic logic [7:0] exp_arr(input int a);
    return 8'((a * 29) % 256) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce0_n = 1'b1; ce1_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tb_oe = 1'b0;
  endtask

  // cen selects which chip enables are pulled low during the write
  task automatic write_cmd(input logic [7:0] b, input logic [1:0] cen);
    @(negedge clk);
    ce0_n = ~cen[0]; ce1_n = ~cen[1]; oe_n = 1'b1;
    tb_drv = b; tb_oe = 1'b1; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    tb_oe = 1'b0; ce0_n = 1'b1; ce1_n = 1'b1;
  endtask

  task automatic read_at(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce0_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    v = data;
    ce0_n = 1'b1; ce1_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 bus idle after reset", data, 8'hzz);
    read_at(6'd0, v);
    check("R1 array mode after reset", v, exp_arr(0));
  endtask

  task automatic t_array();
    logic [7:0] v;
    for (int a = 0; a < 64; a += 7) begin
      read_at(6'(a), v);
      check("R5 array read", v, exp_arr(a));
    end
  endtask

  task automatic t_bus();
    @(negedge clk);
    ce0_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 6'd3;
    @(negedge clk);
    check("R2 driven on read", data, exp_arr(3));
    ce1_n = 1'b1;
    @(negedge clk);
    check("R2 released when ce1_n high", data, 8'hzz);
    ce1_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    check("R2 released when oe_n high", data, 8'hzz);
    idle();
  endtask

  task automatic t_ident();
    logic [7:0] v;
    blk_lock = 4'b0101; blk_efail = 4'b0011;
    write_cmd(8'h90, 2'b11);
    read_at(6'd0, v);  check("R6 manufacturer", v, 8'h89);
    read_at(6'd1, v);  check("R6 manufacturer A0 ignored", v, 8'h89);
    read_at(6'd2, v);  check("R6 device code", v, 8'hD0);
    read_at(6'd3, v);  check("R6 device code A0 ignored", v, 8'hD0);
    for (int b = 0; b < 4; b++) begin
      read_at(6'(b * 16 + 4), v);
      check("R7 block config", v, {6'b0, blk_efail[b], blk_lock[b]});
      read_at(6'(b * 16 + 5), v);
      check("R7 block config A0 ignored", v, {6'b0, blk_efail[b], blk_lock[b]});
    end
    read_at(6'd6, v);  check("R8 unused id word", v, 8'h00);
    read_at(6'd16, v); check("R8 no manufacturer in block 1", v, 8'h00);
    read_at(6'd50, v); check("R8 no device code in block 3", v, 8'h00);
    read_at(6'd0, v);  check("R11 ident mode persists", v, 8'h89);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] v;
    write_cmd(8'h40, 2'b11);
    read_at(6'd0, v); check("R3 invalid byte keeps ident", v, 8'h89);
    write_cmd(8'hFF, 2'b01);
    read_at(6'd0, v); check("R4 write with ce1_n high ignored", v, 8'h89);
    write_cmd(8'hFF, 2'b10);
    read_at(6'd0, v); check("R4 write with ce0_n high ignored", v, 8'h89);
    write_cmd(8'hFF, 2'b11);
    read_at(6'd0, v); check("R3 FFh selects array", v, exp_arr(0));
  endtask

  task automatic t_status();
    logic [7:0] v;
    write_cmd(8'h70, 2'b11);
    status_src = 8'hA5;
    @(negedge clk);
    addr = 6'd9; ce0_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R9 status captured", data, 8'hA5);
    status_src = 8'h3C;
    @(negedge clk);
    check("R9 status held under active read", data, 8'hA5);
    addr = 6'd0;
    @(negedge clk);
    check("R9 status ignores address", data, 8'hA5);
    oe_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    check("R10 refresh after oe_n toggle", data, 8'h3C);
    // last-arriving enable: ce1_n falls after oe_n and ce0_n
    ce1_n = 1'b1; status_src = 8'h11;
    @(negedge clk);
    status_src = 8'h77;
    @(negedge clk);
    ce1_n = 1'b0;
    @(negedge clk);
    check("R9 capture at last enable fall", data, 8'h77);
    idle();
    read_at(6'd5, v); check("R11 status mode persists", v, 8'h77);
    write_cmd(8'h90, 2'b11);
    read_at(6'd0, v); check("R3 90h leaves status", v, 8'h89);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_array();
    t_bus();
    t_ident();
    t_bad_cmd();
    t_status();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule